// File: doc/BRIEF.md
# Eight-pin I/O port with serial-link pin takeover

This block controls a byte-wide bank of general-purpose pins. Software loads a direction register and a data register through two write strobes. For every pin the block produces an output enable, an output level and a pull-up enable for the pad. It also returns the pad levels through a two-stage synchronizer so that a read register can pick them up.

Four of the pins can be lent to a serial peripheral interface (SPI) engine. When the engine is enabled, its role decides which of those pins are forced to be inputs. Master role forces the data-in line to input. Slave role forces the clock, data-out and select lines to input. Pins that stay outputs under their direction bit are driven by the engine's own output levels. A forced input keeps its pull-up under the data register. Pin 3 raises a flag when it is left floating without pull-up, so that an analog comparator can use it. A power-down input blanks the read value.

Top module: `gpio_spi_port`

## Requirements
- R1: A write with `wr_dir` high loads `wdata` into the direction register, and a write with `wr_data` high loads it into the data register. Both strobes may be active together. The new value reaches the pad outputs after that rising edge. While no strobe is high, both registers hold.
- R2: When a pin has direction bit 1 and is not forced to input, `pad_oe` for that pin is 1 and `pad_out` carries its data bit, unless R7 applies.
- R3: When a pin is an input (direction bit 0, or forced), `pad_oe` is 0. `pad_pu` equals the data bit. `pad_pu` and `pad_oe` are never both 1 on the same pin.
- R4: While `rst_n` is low, `pad_oe` and `pad_pu` are all 0, without waiting for a clock edge. After reset both registers read as 0.
- R5: With `spi_en`=1 and `spi_master`=0 (slave), pins 7, 5 and 4 have `pad_oe`=0 whatever their direction bits. Pin 6 follows its direction bit.
- R6: With `spi_en`=1 and `spi_master`=1 (master), pin 6 has `pad_oe`=0 whatever its direction bit. Pins 7, 5 and 4 follow their direction bits.
- R7: When a pin is an output, the SPI engine's level replaces the data bit on `pad_out`. In master role, pin 7 drives `spi_sck_o` and pin 5 drives `spi_mosi_o`. In slave role, pin 6 drives `spi_miso_o`.
- R8: `spi_sel` is 1 exactly when `spi_en`=1, `spi_master`=0, `power_down`=0 and the synchronized level of pin 4 is 0.
- R9: `cmp_analog` is 1 exactly when the direction bit and the data bit of pin 3 are both 0.
- R10: While `power_down` is 1, `pin_rd` reads 0 on every bit.
- R11: With `power_down`=0, `pin_rd` shows `pad_in` two rising edges after the pad changes. One edge after the change it still shows the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_dir | input | 1 | Load `wdata` into the direction register |
| wr_data | input | 1 | Load `wdata` into the data register |
| wdata | input | 8 | Write value |
| spi_en | input | 1 | SPI engine enabled |
| spi_master | input | 1 | SPI role: 1 master, 0 slave |
| spi_sck_o | input | 1 | Clock level from the engine (master role) |
| spi_mosi_o | input | 1 | Data level from the engine (master role) |
| spi_miso_o | input | 1 | Data level from the engine (slave role) |
| power_down | input | 1 | Disconnect the digital input path |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output level |
| pad_pu | output | 8 | Per-pin pull-up enable |
| pin_rd | output | 8 | Synchronized pad levels for the read register |
| spi_sel | output | 1 | Slave selected (active high) |
| cmp_analog | output | 1 | Pin 3 free for comparator use |

## Verification
The hardest situation to reach is a pin whose direction bit says output while the SPI role forces it to input. Its pull-up must still follow the data bit. This has to hold while the role flips between master and slave under unchanged registers. The random loop draws the direction register, the data register, the role and the engine levels independently. Many of its iterations therefore pair direction-1 pins with a forcing role. Directed cases add each role with all direction bits set and with alternating data bits. A reset pulse placed between clock edges checks that the outputs clear without an edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    ROLE_OFF    = 2'd0,
    ROLE_SLAVE  = 2'd1,
    ROLE_MASTER = 2'd2
  } spi_role_e;

  typedef enum logic [2:0] {
    PK_PLAIN = 3'd0,
    PK_CLK   = 3'd1,
    PK_MISO  = 3'd2,
    PK_MOSI  = 3'd3,
    PK_SEL   = 3'd4
  } pin_kind_e;

  function automatic spi_role_e role_of(input logic en, input logic master);
    if (!en)        return ROLE_OFF;
    else if (master) return ROLE_MASTER;
    else            return ROLE_SLAVE;
  endfunction

endpackage

// File: rtl/gpio_reset_sync.sv
module gpio_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    logic [STAGES-1:0] ff_d;

    always_comb begin
      ff_d = {ff_q[STAGES-2:0], async_in[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= '0;
      else        ff_q <= ff_d;
    end

    assign sync_out[b] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_port_pkg::*;
#(
  parameter pin_kind_e KIND = PK_PLAIN
) (
  input  spi_role_e role,
  input  logic      dir_bit,
  input  logic      data_bit,
  input  logic      sck_lvl,
  input  logic      mosi_lvl,
  input  logic      miso_lvl,
  output logic      oe,
  output logic      out_lvl,
  output logic      pu
);
  logic force_in;
  logic alt_drive;
  logic alt_lvl;
  logic eff_dir;

  always_comb begin
    force_in  = 1'b0;
    alt_drive = 1'b0;
    alt_lvl   = 1'b0;
    case (KIND)
      PK_CLK: begin
        force_in  = (role == ROLE_SLAVE);
        alt_drive = (role == ROLE_MASTER);
        alt_lvl   = sck_lvl;
      end
      PK_MOSI: begin
        force_in  = (role == ROLE_SLAVE);
        alt_drive = (role == ROLE_MASTER);
        alt_lvl   = mosi_lvl;
      end
      PK_SEL: begin
        force_in  = (role == ROLE_SLAVE);
      end
      PK_MISO: begin
        force_in  = (role == ROLE_MASTER);
        alt_drive = (role == ROLE_SLAVE);
        alt_lvl   = miso_lvl;
      end
      default: ;
    endcase
    eff_dir = dir_bit & ~force_in;
    oe      = eff_dir;
    out_lvl = alt_drive ? alt_lvl : data_bit;
    pu      = ~eff_dir & data_bit;
  end
endmodule

// File: rtl/gpio_spi_port.sv
module gpio_spi_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CLK_PIN     = 7,
  parameter int MISO_PIN    = 6,
  parameter int MOSI_PIN    = 5,
  parameter int SEL_PIN     = 4,
  parameter int CMP_PIN     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_dir,
  input  logic             wr_data,
  input  logic [WIDTH-1:0] wdata,
  input  logic             spi_en,
  input  logic             spi_master,
  input  logic             spi_sck_o,
  input  logic             spi_mosi_o,
  input  logic             spi_miso_o,
  input  logic             power_down,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pu,
  output logic [WIDTH-1:0] pin_rd,
  output logic             spi_sel,
  output logic             cmp_analog
);
  logic             rst_int_n;
  logic [WIDTH-1:0] dir_q, dir_d;
  logic [WIDTH-1:0] data_q, data_d;
  logic [WIDTH-1:0] pins_sync;
  spi_role_e        role;

  gpio_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    dir_d  = wr_dir  ? wdata : dir_q;
    data_d = wr_data ? wdata : data_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      dir_q  <= '0;
      data_q <= '0;
    end else begin
      dir_q  <= dir_d;
      data_q <= data_d;
    end
  end

  assign role = role_of(spi_en, spi_master);

  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    localparam pin_kind_e KIND = (p == CLK_PIN)  ? PK_CLK  :
                                 (p == MISO_PIN) ? PK_MISO :
                                 (p == MOSI_PIN) ? PK_MOSI :
                                 (p == SEL_PIN)  ? PK_SEL  : PK_PLAIN;
    gpio_pin_ctrl #(.KIND(KIND)) u_pin (
      .role     (role),
      .dir_bit  (dir_q[p]),
      .data_bit (data_q[p]),
      .sck_lvl  (spi_sck_o),
      .mosi_lvl (spi_mosi_o),
      .miso_lvl (spi_miso_o),
      .oe       (pad_oe[p]),
      .out_lvl  (pad_out[p]),
      .pu       (pad_pu[p])
    );
  end

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in (pad_in),
    .sync_out (pins_sync)
  );

  always_comb begin
    pin_rd     = power_down ? '0 : pins_sync;
    spi_sel    = (role == ROLE_SLAVE) & ~power_down & ~pins_sync[SEL_PIN];
    cmp_analog = ~dir_q[CMP_PIN] & ~data_q[CMP_PIN];
  end
endmodule

// File: rtl/gpio_spi_port_chk.sv
module gpio_spi_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spi_en,
  input logic             spi_master,
  input logic             power_down,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_pu,
  input logic [WIDTH-1:0] pin_rd,
  input logic             spi_sel,
  input logic             cmp_analog
);
  AST_PU_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pu) == '0);  // R3

  AST_SLAVE_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && !spi_master) |-> (!pad_oe[7] && !pad_oe[5] && !pad_oe[4]));  // R5

  AST_MASTER_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && spi_master) |-> !pad_oe[6]);  // R6

  AST_SEL_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sel |-> (spi_en && !spi_master && !power_down));  // R8

  AST_ANALOG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_analog |-> (!pad_oe[3] && !pad_pu[3]));  // R9

  AST_PD_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> (pin_rd == '0));  // R10

  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      AST_RESET_TRISTATE: assert (pad_oe == '0 && pad_pu == '0);  // R4
    end
  end
endmodule

bind gpio_spi_port gpio_spi_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spi_en     (spi_en),
  .spi_master (spi_master),
  .power_down (power_down),
  .pad_oe     (pad_oe),
  .pad_pu     (pad_pu),
  .pin_rd     (pin_rd),
  .spi_sel    (spi_sel),
  .cmp_analog (cmp_analog)
);

// File: tb/test_gpio_spi_port.sv
module test_gpio_spi_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_dir, wr_data;
  logic [7:0] wdata;
  logic       spi_en, spi_master, spi_sck_o, spi_mosi_o, spi_miso_o;
  logic       power_down;
  logic [7:0] pad_in;
  logic [7:0] pad_oe, pad_out, pad_pu, pin_rd;
  logic       spi_sel, cmp_analog;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_dir, m_data;

  always #2 clk = ~clk;

  gpio_spi_port i_gpio_spi_port (
    .clk(clk), .rst_n(rst_n), .wr_dir(wr_dir), .wr_data(wr_data), .wdata(wdata),
    .spi_en(spi_en), .spi_master(spi_master), .spi_sck_o(spi_sck_o),
    .spi_mosi_o(spi_mosi_o), .spi_miso_o(spi_miso_o), .power_down(power_down),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
    .pin_rd(pin_rd), .spi_sel(spi_sel), .cmp_analog(cmp_analog)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] forced_mask(input logic en, input logic ms);
    if (!en) return 8'h00;
    return ms ? 8'b0100_0000 : 8'b1011_0000;  // R6 master pin 6; R5 slave pins 7,5,4
  endfunction

  function automatic logic [7:0] exp_oe(input logic [7:0] d, input logic en, input logic ms);
    return d & ~forced_mask(en, ms);
  endfunction

  function automatic logic [7:0] exp_pu(input logic [7:0] d, input logic [7:0] v,
                                        input logic en, input logic ms);
    return ~exp_oe(d, en, ms) & v;
  endfunction

  function automatic logic [7:0] exp_out(input logic [7:0] v, input logic en, input logic ms,
                                         input logic sck, input logic mosi, input logic miso);
    logic [7:0] r = v;
    if (en && ms) begin r[7] = sck; r[5] = mosi; end
    if (en && !ms) r[6] = miso;
    return r;
  endfunction

  task automatic write_regs(input logic [7:0] d, input logic [7:0] v);
    @(negedge clk); wr_dir = 1'b1; wr_data = 1'b1; wdata = d;
    if (d != v) begin
      wr_data = 1'b0;
      @(negedge clk); wr_dir = 1'b0; wr_data = 1'b1; wdata = v;
    end
    @(negedge clk); wr_dir = 1'b0; wr_data = 1'b0; wdata = $urandom;
    m_dir = d; m_data = v;
  endtask

  task automatic check_pads();
    chk("R2 oe", pad_oe, exp_oe(m_dir, spi_en, spi_master));
    chk("R3 pu", pad_pu, exp_pu(m_dir, m_data, spi_en, spi_master));
    chk("R7 out", pad_out & pad_oe,
        exp_out(m_data, spi_en, spi_master, spi_sck_o, spi_mosi_o, spi_miso_o)
        & exp_oe(m_dir, spi_en, spi_master));
    chk("R9 analog", {7'd0, cmp_analog}, {7'd0, ~m_dir[3] & ~m_data[3]});
  endtask

  initial begin
    #150000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; wr_dir = 0; wr_data = 0; wdata = 0; spi_en = 0; spi_master = 0;
    spi_sck_o = 0; spi_mosi_o = 0; spi_miso_o = 0; power_down = 0; pad_in = 8'h00;
    repeat (3) @(negedge clk);
    chk("R4 reset oe", pad_oe, 8'h00);
    chk("R4 reset pu", pad_pu, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_dir = 0; m_data = 0;
    check_pads();

    // R1: both strobes in one cycle, then holds
    write_regs(8'hA5, 8'hA5);
    check_pads();
    repeat (2) @(negedge clk);
    chk("R1 hold", pad_oe, 8'hA5);

    // R5/R6/R7 directed: all direction bits set, alternating data
    write_regs(8'hFF, 8'h55);
    spi_en = 1; spi_master = 0; spi_miso_o = 1; #1;
    chk("R5 slave oe", pad_oe, 8'b0100_1111);
    chk("R6 forced pull-up", pad_pu, 8'b0001_0000);
    chk("R7 miso", {7'd0, pad_out[6]}, 8'd1);
    spi_master = 1; spi_sck_o = 0; spi_mosi_o = 1; #1;
    chk("R6 master oe", pad_oe, 8'b1011_1111);
    chk("R7 sck/mosi", {6'd0, pad_out[7], pad_out[5]}, 8'b01);
    spi_en = 0; #1;
    chk("R2 spi off", pad_out, 8'h55);

    // R11 latency and R8 select
    @(negedge clk); pad_in = 8'h3C;
    @(negedge clk); chk("R11 one edge", pin_rd, 8'h00);
    @(negedge clk); chk("R11 two edges", pin_rd, 8'h3C);
    spi_en = 1; spi_master = 0; pad_in = 8'h00;
    repeat (2) @(negedge clk);
    chk("R8 sel low pin", {7'd0, spi_sel}, 8'd1);
    power_down = 1; #1;
    chk("R10 pd read", pin_rd, 8'h00);
    chk("R8 sel in pd", {7'd0, spi_sel}, 8'd0);
    power_down = 0; pad_in = 8'hFF;
    repeat (2) @(negedge clk);
    chk("R8 sel high pin", {7'd0, spi_sel}, 8'd0);
    spi_en = 0;

    // R4 asynchronous reset between edges
    write_regs(8'hFF, 8'hFF);
    #1 rst_n = 1'b0; #0.5;
    chk("R4 async oe", pad_oe, 8'h00);
    chk("R4 async pu", pad_pu, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_dir = 0; m_data = 0;
    check_pads();

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [7:0] d, v, p;
      d = $urandom; v = $urandom; p = $urandom;
      write_regs(d, v);
      spi_en = $urandom; spi_master = $urandom;
      spi_sck_o = $urandom; spi_mosi_o = $urandom; spi_miso_o = $urandom;
      power_down = ($urandom % 4) == 0;
      pad_in = p;
      repeat (2) @(negedge clk);
      check_pads();
      chk("R10/R11 read", pin_rd, power_down ? 8'h00 : p);
      chk("R8 sel", {7'd0, spi_sel},
          {7'd0, spi_en & ~spi_master & ~power_down & ~p[4]});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule